// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Controller

This block takes bytes from a rate-adaptation serial receiver and stores them in buffers that a host has set up. Each buffer is described by an entry in a small ring of receive descriptors, and the ring sits in a local table. The host reads and writes that table through a word-wide register port. Ownership of an entry passes between host and controller through its empty flag. The host arms an entry by setting the flag. The controller fills the buffer and then writes back the byte count and the error bits. Clearing the flag returns the entry to the host.

Received bytes leave the block through a one-deep write request port aimed at buffer memory. The request carries a 24-bit address and a flag that selects the local or the external memory space. The controller checks every byte for a synchronization fault. It detects overruns in two cases: a byte arrives before the previous one is written, or a byte arrives while the current entry still belongs to the host. It closes a buffer early on an error, or normally once a configurable maximum length is reached. It then moves on to the next entry, or back to entry 0 when the wrap flag is set.

Top module: `rxring_top`

## Requirements
- R1: After reset, memReq is low, every table word reads 0 and the max-length register reads 16.
- R2: Host map (word address): entry n uses n*4+0 for the control word, n*4+1 for the length, n*4+2 for pointer bits 23:16 (low byte, upper byte reads 0) and n*4+3 for pointer bits 15:0. Address NUM_BD*4 holds the max length. Control bits: empty = 15, external = 14, wrap = 13, sync error = 3, overrun = 1. All other control bits read 0.
- R3: A byte accepted into an empty entry raises memReq with memAddr = pointer + bytes already written, memData = the byte and memExt = the external bit. These stay stable until memAck.
- R4: A nonzero byte whose bit 7 is 0 is not written. It closes the entry with the sync error bit set and length = bytes written. The all-zero byte is stored normally.
- R5: When the written count reaches the max length, the entry closes. Empty is cleared, length = max length, and no error bit is set unless R7 applies.
- R6: A byte that arrives while a request is outstanding and memAck is low cancels the request. It closes the entry with the overrun bit set and length = bytes written.
- R7: A byte that arrives while the current entry's empty bit is clear is dropped. Table and memory are left unchanged, and the next entry to close gets its overrun bit set.
- R8: After closing an entry whose wrap bit is set, the next entry used is 0. Otherwise it is the following entry, and the entry after entry NUM_BD-1 is 0.
- R9: Closing an entry keeps its external and wrap bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Received byte strobe, one cycle per byte |
| rxData | input | 8 | Received byte |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 6 | Host word address |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data for hostAddr (combinational) |
| memReq | output | 1 | Buffer write request |
| memAck | input | 1 | Write accepted this cycle |
| memAddr | output | 24 | Buffer byte address |
| memData | output | 8 | Byte to write |
| memExt | output | 1 | 1 = external memory, 0 = local memory |

## Verification
The assertions assume that rxValid is a one-cycle strobe and that memAck is only high while memReq is high. They also assume the host does not rewrite the active entry while it is being filled. The stimulus keeps to these rules. The memory model acknowledges only outstanding requests. Every host table write happens while no bytes are flowing and no request is pending. Overruns are created only by withholding memAck, never by glitching rxValid.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 24;
  localparam int HI_W   = PTR_W - WORD_W;

  localparam int BIT_E  = 15;
  localparam int BIT_X  = 14;
  localparam int BIT_W  = 13;
  localparam int BIT_SE = 3;
  localparam int BIT_OV = 1;
  localparam logic [WORD_W-1:0] CTRL_MASK = 16'hE00A;

  typedef struct packed {
    logic              close;
    logic              se;
    logic              ov;
    logic [WORD_W-1:0] len;
  } closeStb_t;
endpackage

// File: rtl/rxring_table.sv
module rxring_table
  import rxring_pkg::*;
#(
  parameter int NUM_BD  = 8,
  parameter int DEF_MAX = 16,
  localparam int IDX_W  = (NUM_BD > 1) ? $clog2(NUM_BD) : 1,
  localparam int HA_W   = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [HA_W-1:0]   hostAddr,
  input  logic [WORD_W-1:0] hostWdata,
  output logic [WORD_W-1:0] hostRdata,
  input  logic [IDX_W-1:0]  curIdx,
  input  closeStb_t         stb,
  output logic              curE,
  output logic              curX,
  output logic [PTR_W-1:0]  curPtr,
  output logic [WORD_W-1:0] maxLen
);
  logic [WORD_W-1:0] ctrlW [NUM_BD];
  logic [WORD_W-1:0] lenW  [NUM_BD];
  logic [HI_W-1:0]   ptrHi [NUM_BD];
  logic [WORD_W-1:0] ptrLo [NUM_BD];

  logic             cfgSel;
  logic [IDX_W-1:0] selBd;
  logic [1:0]       selWord;

  assign cfgSel  = hostAddr[HA_W-1];
  assign selBd   = hostAddr[IDX_W+1:2];
  assign selWord = hostAddr[1:0];

  for (genvar g = 0; g < NUM_BD; g++) begin : g_bd
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlW[g] <= '0;
        lenW[g]  <= '0;
        ptrHi[g] <= '0;
        ptrLo[g] <= '0;
      end else if (stb.close && curIdx == IDX_W'(g)) begin
        ctrlW[g] <= (ctrlW[g] & ((WORD_W'(1) << BIT_X) | (WORD_W'(1) << BIT_W)))
                  | (WORD_W'(stb.se) << BIT_SE) | (WORD_W'(stb.ov) << BIT_OV);
        lenW[g]  <= stb.len;
      end else if (hostWe && !cfgSel && selBd == IDX_W'(g)) begin
        case (selWord)
          2'd0:    ctrlW[g] <= hostWdata & CTRL_MASK;
          2'd1:    lenW[g]  <= hostWdata;
          2'd2:    ptrHi[g] <= hostWdata[HI_W-1:0];
          default: ptrLo[g] <= hostWdata;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 maxLen <= WORD_W'(DEF_MAX);
    else if (hostWe && cfgSel) maxLen <= hostWdata;
  end

  always_comb begin
    hostRdata = '0;
    if (cfgSel) hostRdata = maxLen;
    else if (int'(selBd) < NUM_BD) begin
      case (selWord)
        2'd0:    hostRdata = ctrlW[selBd];
        2'd1:    hostRdata = lenW[selBd];
        2'd2:    hostRdata = {{(WORD_W-HI_W){1'b0}}, ptrHi[selBd]};
        default: hostRdata = ptrLo[selBd];
      endcase
    end
  end

  assign curE   = ctrlW[curIdx][BIT_E];
  assign curX   = ctrlW[curIdx][BIT_X];
  assign curPtr = {ptrHi[curIdx], ptrLo[curIdx]};

  logic curW;
  assign curW = ctrlW[curIdx][BIT_W];
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
#(
  parameter int NUM_BD = 8,
  localparam int IDX_W = (NUM_BD > 1) ? $clog2(NUM_BD) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              memAck,
  input  logic              curE,
  input  logic              curX,
  input  logic              curW,
  input  logic [PTR_W-1:0]  curPtr,
  input  logic [WORD_W-1:0] maxLen,
  output logic [IDX_W-1:0]  curIdx,
  output closeStb_t         stb,
  output logic              memReq,
  output logic [PTR_W-1:0]  memAddr,
  output logic [BYTE_W-1:0] memData,
  output logic              memExt
);
  logic [WORD_W-1:0] count, cntNext;
  logic              lostFlag;
  logic              done, lastDone, seByte;
  logic              issue, lost, cancel;

  assign done     = memReq && memAck;
  assign cntNext  = count + WORD_W'(done);
  assign lastDone = done && (count + WORD_W'(1) == maxLen);
  assign seByte   = !rxData[BYTE_W-1] && (rxData != '0);

  always_comb begin
    stb    = '0;
    issue  = 1'b0;
    lost   = 1'b0;
    cancel = 1'b0;
    if (rxValid && memReq && !memAck) begin
      stb.close = 1'b1;
      stb.ov    = 1'b1;
      stb.len   = count;
      cancel    = 1'b1;
    end else if (lastDone) begin
      stb.close = 1'b1;
      stb.len   = maxLen;
      lost      = rxValid;
    end else if (rxValid) begin
      if (!curE) lost = 1'b1;
      else if (seByte) begin
        stb.close = 1'b1;
        stb.se    = 1'b1;
        stb.len   = cntNext;
      end else issue = 1'b1;
    end
    if (stb.close && lostFlag) stb.ov = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      curIdx   <= '0;
      lostFlag <= 1'b0;
      memReq   <= 1'b0;
      memAddr  <= '0;
      memData  <= '0;
      memExt   <= 1'b0;
    end else begin
      if (stb.close) begin
        count    <= '0;
        lostFlag <= lost;
        if (curW || curIdx == IDX_W'(NUM_BD - 1)) curIdx <= '0;
        else                                      curIdx <= curIdx + IDX_W'(1);
      end else begin
        count <= cntNext;
        if (lost) lostFlag <= 1'b1;
      end
      if (issue) begin
        memReq  <= 1'b1;
        memAddr <= curPtr + PTR_W'(cntNext);
        memData <= rxData;
        memExt  <= curX;
      end else if (cancel || done) begin
        memReq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxring_top.sv
module rxring_top
  import rxring_pkg::*;
#(
  parameter int NUM_BD  = 8,
  parameter int DEF_MAX = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxValid,
  input  logic [7:0]   rxData,
  input  logic         hostWe,
  input  logic [5:0]   hostAddr,
  input  logic [15:0]  hostWdata,
  output logic [15:0]  hostRdata,
  output logic         memReq,
  input  logic         memAck,
  output logic [23:0]  memAddr,
  output logic [7:0]   memData,
  output logic         memExt
);
  localparam int IDX_W = (NUM_BD > 1) ? $clog2(NUM_BD) : 1;

  logic [IDX_W-1:0]  curIdx;
  closeStb_t         stb;
  logic              curE, curX, curW;
  logic [PTR_W-1:0]  curPtr;
  logic [WORD_W-1:0] maxLen;

  rxring_table #(.NUM_BD(NUM_BD), .DEF_MAX(DEF_MAX)) uTable (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .curIdx(curIdx), .stb(stb),
    .curE(curE), .curX(curX), .curPtr(curPtr), .maxLen(maxLen)
  );

  assign curW = uTable.curW;

  rxring_ctrl #(.NUM_BD(NUM_BD)) uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .memAck(memAck),
    .curE(curE), .curX(curX), .curW(curW), .curPtr(curPtr), .maxLen(maxLen),
    .curIdx(curIdx), .stb(stb), .memReq(memReq), .memAddr(memAddr),
    .memData(memData), .memExt(memExt)
  );
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rxValid,
  input logic [7:0]  rxData,
  input logic        memReq,
  input logic        memAck,
  input logic [23:0] memAddr,
  input logic [7:0]  memData,
  input logic        memExt
);
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && !rxValid |=> memReq && $stable(memAddr) && $stable(memData) && $stable(memExt));

  a_r3_data_from_input: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(rxValid) && memData == $past(rxData));

  a_r4_se_no_write: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !(memReq && !memAck) && !rxData[7] && rxData != 8'h00 |=> !memReq);

  a_r6_overrun_cancel: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && memReq && !memAck |=> !memReq);
endmodule

bind rxring_top rxring_chk uChk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .memReq(memReq),
  .memAck(memAck), .memAddr(memAddr), .memData(memData), .memExt(memExt)
);

// File: tb/sim_rxring_top.sv
module sim_rxring_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        hostWe = 1'b0;
  logic [5:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        memReq, memAck, memExt;
  logic [23:0] memAddr;
  logic [7:0]  memData;
  logic        ackEn = 1'b1;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  logic [7:0] memModel [256];
  logic       extLog   [256];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign memAck = memReq & ackEn;

  rxring_top u0 (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .memReq(memReq), .memAck(memAck), .memAddr(memAddr), .memData(memData), .memExt(memExt)
  );

  always @(posedge clk) if (memReq && memAck) begin
    memModel[memAddr[7:0]] <= memData;
    extLog[memAddr[7:0]]   <= memExt;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hostWr(input int addr, input logic [15:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = 6'(addr); hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostChk(input string req, input int addr, input logic [15:0] exp);
    @(negedge clk);
    hostAddr = 6'(addr);
    #1;
    check(req, 32'(hostRdata), 32'(exp));
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic armBd(input int n, input logic [15:0] ptr, input logic [15:0] ctrl);
    hostWr(n*4+3, ptr);
    hostWr(n*4+0, ctrl);
  endtask

  task automatic testReset();
    check("R1 memReq", 32'(memReq), 0);
    hostChk("R1 ctrl0", 0, 16'h0000);
    hostChk("R1 ptr7", 31, 16'h0000);
    hostChk("R1 maxlen", 32, 16'd16);
  endtask

  task automatic testFill();
    armBd(0, 16'h0010, 16'h8000);
    armBd(1, 16'h0020, 16'hA000);
    hostWr(32, 16'd4);
    for (int i = 0; i < 4; i++) begin sendByte(8'h81 + 8'(i)); idle(2); end
    for (int i = 0; i < 4; i++) check("R3 data", 32'(memModel[8'h10 + 8'(i)]), 32'(8'h81 + 8'(i)));
    hostChk("R5 ctrl cleared", 0, 16'h0000);
    hostChk("R5 length", 1, 16'd4);
  endtask

  task automatic testSync();
    sendByte(8'h00); idle(2);
    sendByte(8'h45); idle(2);
    check("R4 zero byte stored", 32'(memModel[8'h20]), 32'h00);
    check("R4 bad byte not written", 32'(memModel[8'h21]), 32'hEE);
    hostChk("R4 R9 ctrl SE keep W", 4, 16'h2008);
    hostChk("R4 length", 5, 16'd1);
  endtask

  task automatic testOverrun();
    armBd(0, 16'h0030, 16'hC000);
    sendByte(8'h90); idle(2);
    check("R3 ext flag", 32'(extLog[8'h30]), 1);
    ackEn = 1'b0;
    sendByte(8'h91);
    check("R3 req addr", 32'(memAddr), 32'h000031);
    check("R3 req ext", 32'(memExt), 1);
    idle(1);
    check("R3 held", 32'(memReq), 1);
    sendByte(8'h92);
    check("R6 cancelled", 32'(memReq), 0);
    ackEn = 1'b1;
    idle(2);
    check("R6 no write", 32'(memModel[8'h31]), 32'hEE);
    hostChk("R6 R9 ctrl OV keep X", 0, 16'h4002);
    hostChk("R6 length", 1, 16'd1);
  endtask

  task automatic testNotEmpty();
    sendByte(8'h77); idle(2);
    check("R7 no request", 32'(memReq), 0);
    hostChk("R7 ctrl unchanged", 4, 16'h2008);
    hostChk("R7 length unchanged", 5, 16'd1);
    armBd(1, 16'h0040, 16'hA000);
    hostWr(32, 16'd2);
    sendByte(8'h85); idle(2);
    sendByte(8'h86); idle(2);
    check("R7 byte a", 32'(memModel[8'h40]), 32'h85);
    check("R7 byte b", 32'(memModel[8'h41]), 32'h86);
    hostChk("R7 OV on next close", 4, 16'h2002);
    hostChk("R5 length max", 5, 16'd2);
  endtask

  task automatic testRing();
    hostWr(32, 16'd1);
    for (int i = 0; i < 8; i++) armBd(i, 16'(16'h0080 + 16'(i*16)), 16'h8000);
    for (int i = 0; i < 8; i++) begin sendByte(8'hA0 + 8'(i)); idle(2); end
    for (int i = 0; i < 8; i++) begin
      check("R8 order", 32'(memModel[8'h80 + 8'(i*16)]), 32'(8'hA0 + 8'(i)));
      hostChk("R8 closed", i*4, 16'h0000);
    end
    armBd(0, 16'h0008, 16'h8000);
    sendByte(8'hB5); idle(2);
    check("R8 wrap past last", 32'(memModel[8'h08]), 32'hB5);
    hostChk("R8 entry0 closed", 0, 16'h0000);
  endtask

  task automatic testMap();
    hostWr(8, 16'hFFFF);
    hostChk("R2 reserved zero", 8, 16'hE00A);
    hostWr(10, 16'hABCD);
    hostChk("R2 ptr high byte", 10, 16'h00CD);
    hostWr(9, 16'h1234);
    hostChk("R2 length word", 9, 16'h1234);
    hostChk("R2 maxlen", 32, 16'd1);
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin memModel[i] = 8'hEE; extLog[i] = 1'b0; end
    idle(3);
    testReset();
    @(negedge clk); rstN = 1'b1;
    idle(1);
    testReset();
    testFill();
    testSync();
    testOverrun();
    testNotEmpty();
    testRing();
    testMap();
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule